// File: doc/BRIEF.md
# Deferred-Store Direct-Mapped Cache Front End

This block sits between a processor's memory stage and the tag and data storage of a direct-mapped data cache. It removes the second cycle a store hit would normally need. A store spends one cycle on its tag lookup. If the lookup hits, the store's word address, data and byte enables are parked in a one-entry holding register. The data array is written from that register later, in the cycle when the next store hit does its own tag lookup. At that point the data array's write port is otherwise unused.

Loads read the tag and data arrays in the same cycle as the request. If a load's word address equals the parked word address, the parked bytes are merged over the array word, so a load never sees the stale array copy. A separate flush input empties the holding register into the array in a cycle with no store. Line refill is outside this block: a miss is only reported on the hit output.

Both arrays live outside the block. They are read asynchronously through index outputs. The data array receives one byte-masked write per cycle at most.

Top module: `dly_store_cache`

## Requirements
- R1: A load is valid and not a store. It reports `rsp_hit`=1 when the tag entry at its index is valid and equal to address bits [11:7]. When the word does not match the parked entry, `rsp_rdata` is the data array word at slot address bits [6:2]. Requests are word aligned, meaning address bits [1:0] are 0.
- R2: A store whose tag lookup hits reports `rsp_hit`=1 in its own cycle. Its address, data and byte enables are held in the pending register from the next cycle. No data array write happens in its own cycle unless an older entry was already pending.
- R3: When a store hits while an entry is pending, `daw_en`=1 in that same cycle. In that cycle `daw_addr` is the pending slot address, `daw_data` the pending data and `daw_be` the pending enables. The new store then replaces the entry.
- R4: A store whose tag lookup misses reports `rsp_hit`=0. It writes nothing to the data array and leaves the pending entry unchanged.
- R5: A load whose word address matches the pending entry returns the pending byte for each lane whose enable bit is 1. Lane k is bits [8k+7:8k]. For the other lanes it returns the data array byte.
- R6: Forwarding needs equality of the full word address, that is tag, index and word offset. A load that differs in any of these reads the data array only.
- R7: A load that matches the pending entry reports `rsp_hit`=1 even when the tag array no longer holds its tag.
- R8: `flush` asserted with no store request writes a pending entry into the data array and empties the register. A second flush then writes nothing.
- R9: Synchronous active-high reset empties the pending register. After reset, loads read only the array, and the first store hit causes no data array write.
- R10: With `req_valid`=0, `rsp_hit` is 0. A data array write happens only through a flush.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_addr | input | 12 | Byte address, word aligned |
| req_wdata | input | 32 | Store data |
| req_be | input | 4 | Store byte enables |
| flush | input | 1 | Drain the pending entry when no store is present |
| rsp_hit | output | 1 | Hit indication for the current request |
| rsp_rdata | output | 32 | Load data (0 for non-loads) |
| tag_idx | output | 3 | Tag array read index |
| tag_rd_valid | input | 1 | Valid bit of the indexed tag entry |
| tag_rd_tag | input | 5 | Tag of the indexed entry |
| dar_addr | output | 5 | Data array read slot |
| dar_rdata | input | 32 | Data array read word |
| daw_en | output | 1 | Data array write enable |
| daw_addr | output | 5 | Data array write slot |
| daw_data | output | 32 | Data array write data |
| daw_be | output | 4 | Data array write byte enables |

## Verification
The bench targets these corner cases:
- A load of the word whose store is still parked. Without forwarding or the byte merge, the load returns stale array bytes.
- A load that shares the slot but has a different tag or word offset. A design that compares too few address bits would forward wrongly here.
- A store miss arriving while an entry is parked. A design that drained or overwrote the entry on a miss would lose or corrupt data.
- A parked line whose tag is removed from the tag array. A hit computed from the tag alone would report a miss for that load.

A long pseudo-random sweep mixes loads, hits, misses, flushes and idle cycles. After a final flush it compares the whole data array with an arithmetic model in which each store hit takes effect at once.

// File: rtl/dsb_pkg.sv
package dsb_pkg;
    parameter int unsigned ADDR_W  = 12;
    parameter int unsigned DATA_W  = 32;
    parameter int unsigned INDEX_W = 3;
    parameter int unsigned WOFF_W  = 2;

    localparam int unsigned BE_W    = DATA_W / 8;
    localparam int unsigned BOFF_W  = $clog2(BE_W);
    localparam int unsigned WADDR_W = ADDR_W - BOFF_W;
    localparam int unsigned SLOT_W  = INDEX_W + WOFF_W;
    localparam int unsigned TAG_W   = WADDR_W - SLOT_W;

    typedef logic [WADDR_W-1:0] waddr_t;
    typedef logic [DATA_W-1:0]  word_t;
    typedef logic [BE_W-1:0]    be_t;
    typedef logic [TAG_W-1:0]   tag_t;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_LOAD  = 2'd1,
        OP_STORE = 2'd2
    } op_e;

    typedef struct packed {
        logic   vld;
        waddr_t wa;
        word_t  data;
        be_t    be;
    } pend_t;

    function automatic word_t lane_mask(input be_t be);
        word_t m;
        for (int i = 0; i < int'(BE_W); i++) begin
            m[i*8 +: 8] = {8{be[i]}};
        end
        return m;
    endfunction
endpackage

// File: rtl/dsb_tag_check.sv
module dsb_tag_check
    import dsb_pkg::*;
(
    input  tag_t req_tag,
    input  logic ent_valid,
    input  tag_t ent_tag,
    output logic tag_hit
);
    always_comb begin
        tag_hit = ent_valid && (ent_tag == req_tag);
    end
endmodule

// File: rtl/dsb_pend_reg.sv
module dsb_pend_reg
    import dsb_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   cap_en,
    input  logic   drain_en,
    input  waddr_t new_wa,
    input  word_t  new_data,
    input  be_t    new_be,
    output pend_t  q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (cap_en) begin
            q <= '{vld: 1'b1, wa: new_wa, data: new_data, be: new_be};
        end else if (drain_en) begin
            q.vld <= 1'b0;
        end
    end

    assert_capture_R2: assert property (@(posedge clk) disable iff (rst)
        cap_en |=> (q.vld && q.wa == $past(new_wa) && q.data == $past(new_data)));

    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!cap_en && !drain_en) |=> $stable(q));

    assert_empty_after_drain_R8: assert property (@(posedge clk) disable iff (rst)
        (drain_en && !cap_en) |=> !q.vld);
endmodule

// File: rtl/dsb_fwd.sv
module dsb_fwd
    import dsb_pkg::*;
(
    input  pend_t  pend,
    input  waddr_t ld_wa,
    input  word_t  arr_word,
    output logic   match,
    output word_t  merged
);
    word_t mask;

    always_comb begin
        match  = pend.vld && (pend.wa == ld_wa);
        mask   = match ? lane_mask(pend.be) : '0;
        merged = (pend.data & mask) | (arr_word & ~mask);
    end
endmodule

// File: rtl/dly_store_cache.sv
module dly_store_cache
    import dsb_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic                req_store,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic [BE_W-1:0]     req_be,
    input  logic                flush,
    output logic                rsp_hit,
    output logic [DATA_W-1:0]   rsp_rdata,
    output logic [INDEX_W-1:0]  tag_idx,
    input  logic                tag_rd_valid,
    input  logic [TAG_W-1:0]    tag_rd_tag,
    output logic [SLOT_W-1:0]   dar_addr,
    input  logic [DATA_W-1:0]   dar_rdata,
    output logic                daw_en,
    output logic [SLOT_W-1:0]   daw_addr,
    output logic [DATA_W-1:0]   daw_data,
    output logic [BE_W-1:0]     daw_be
);
    op_e    op;
    waddr_t wa;
    tag_t   req_tag;
    logic   tag_hit;
    logic   st_hit;
    logic   drain;
    logic   fwd_match;
    word_t  fwd_word;
    pend_t  pend;

    always_comb begin
        if (!req_valid)     op = OP_IDLE;
        else if (req_store) op = OP_STORE;
        else                op = OP_LOAD;
    end

    assign wa       = req_addr[ADDR_W-1:BOFF_W];
    assign req_tag  = wa[WADDR_W-1:SLOT_W];
    assign tag_idx  = wa[SLOT_W-1:WOFF_W];
    assign dar_addr = wa[SLOT_W-1:0];

    dsb_tag_check u_tag (
        .req_tag   (req_tag),
        .ent_valid (tag_rd_valid),
        .ent_tag   (tag_rd_tag),
        .tag_hit   (tag_hit)
    );

    assign st_hit = (op == OP_STORE) && tag_hit;
    assign drain  = pend.vld && (st_hit || (flush && op != OP_STORE));

    dsb_pend_reg u_pend (
        .clk      (clk),
        .rst      (rst),
        .cap_en   (st_hit),
        .drain_en (drain),
        .new_wa   (wa),
        .new_data (req_wdata),
        .new_be   (req_be),
        .q        (pend)
    );

    dsb_fwd u_fwd (
        .pend     (pend),
        .ld_wa    (wa),
        .arr_word (dar_rdata),
        .match    (fwd_match),
        .merged   (fwd_word)
    );

    always_comb begin
        rsp_hit   = 1'b0;
        rsp_rdata = '0;
        unique case (op)
            OP_LOAD: begin
                rsp_hit   = tag_hit || fwd_match;
                rsp_rdata = fwd_word;
            end
            OP_STORE: rsp_hit = tag_hit;
            default: ;
        endcase
    end

    assign daw_en   = drain;
    assign daw_addr = pend.wa[SLOT_W-1:0];
    assign daw_data = pend.data;
    assign daw_be   = pend.be;

    assert_aligned_R1: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (req_addr[BOFF_W-1:0] == '0));

    assert_fwd_hit_R7: assert property (@(posedge clk) disable iff (rst)
        (op == OP_LOAD && fwd_match) |-> rsp_hit);

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> (!rsp_hit && (!daw_en || flush)));

    assert_store_miss_no_write_R4: assert property (@(posedge clk) disable iff (rst)
        (op == OP_STORE && !tag_hit) |-> !daw_en);

    assert_second_store_drains_R3: assert property (@(posedge clk) disable iff (rst)
        st_hit |=> (st_hit -> (daw_en && daw_addr == $past(dar_addr))));
endmodule

// File: tb/sim_dly_store_cache.sv
module sim_dly_store_cache;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_store = 1'b0, flush = 1'b0;
    logic [11:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  req_be = '0;
    logic        rsp_hit, daw_en, tag_rd_valid;
    logic [31:0] rsp_rdata, dar_rdata, daw_data;
    logic [2:0]  tag_idx;
    logic [4:0]  tag_rd_tag, dar_addr, daw_addr;
    logic [3:0]  daw_be;

    logic [4:0]  btag [8];
    logic        bvld [8];
    logic [31:0] bmem [32];
    logic [31:0] ref_full [32];

    logic        pv;
    logic [9:0]  pwa;
    logic [31:0] pd;
    logic [3:0]  pbe;
    logic        after_rst;
    logic [31:0] lfsr;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    assign tag_rd_valid = bvld[tag_idx];
    assign tag_rd_tag   = btag[tag_idx];
    assign dar_rdata    = bmem[dar_addr];

    dly_store_cache u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_store(req_store),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be), .flush(flush),
        .rsp_hit(rsp_hit), .rsp_rdata(rsp_rdata), .tag_idx(tag_idx),
        .tag_rd_valid(tag_rd_valid), .tag_rd_tag(tag_rd_tag), .dar_addr(dar_addr),
        .dar_rdata(dar_rdata), .daw_en(daw_en), .daw_addr(daw_addr),
        .daw_data(daw_data), .daw_be(daw_be)
    );

    function automatic logic [31:0] bmerge(input logic [31:0] nw, input logic [31:0] od,
                                           input logic [3:0] be);
        logic [31:0] r;
        for (int k = 0; k < 4; k++) r[k*8 +: 8] = be[k] ? nw[k*8 +: 8] : od[k*8 +: 8];
        return r;
    endfunction

    function automatic logic [11:0] mk(input logic [4:0] t, input logic [2:0] i,
                                       input logic [1:0] o);
        return {t, i, o, 2'b00};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input bit v, input bit st, input logic [11:0] a,
                        input logic [31:0] wd, input logic [3:0] be, input bit fl);
        logic [9:0]  wa;
        logic [4:0]  slot;
        bit thit, isl, iss, match, exp_hit, exp_drain;
        logic [31:0] exp_rd;
        @(negedge clk);
        req_valid = v; req_store = st; req_addr = a; req_wdata = wd; req_be = be; flush = fl;
        #1;
        wa   = a[11:2];
        slot = wa[4:0];
        thit = bvld[wa[4:2]] && (btag[wa[4:2]] == wa[9:5]);
        isl  = v && !st;
        iss  = v && st;
        match = pv && (pwa == wa);
        exp_hit   = (isl && (thit || match)) || (iss && thit);
        exp_drain = pv && ((iss && thit) || (fl && !iss));
        if (!v)
            chk(rsp_hit == 1'b0, "R10 idle hit", {31'b0, rsp_hit}, 32'd0);
        else if (isl)
            chk(rsp_hit == exp_hit, (match && !thit) ? "R7 load hit" : "R1 load hit",
                {31'b0, rsp_hit}, {31'b0, exp_hit});
        else
            chk(rsp_hit == exp_hit, thit ? "R2 store hit" : "R4 store miss",
                {31'b0, rsp_hit}, {31'b0, exp_hit});
        chk(daw_en == exp_drain, after_rst ? "R9 write enable" : (fl ? "R8 write enable" : "R3 write enable"),
            {31'b0, daw_en}, {31'b0, exp_drain});
        if (exp_drain && daw_en) begin
            chk(daw_addr == pwa[4:0], "R3 drain slot", {27'b0, daw_addr}, {27'b0, pwa[4:0]});
            chk(daw_data == pd, "R3 drain data", daw_data, pd);
            chk(daw_be == pbe, "R3 drain enables", {28'b0, daw_be}, {28'b0, pbe});
        end
        if (isl && exp_hit) begin
            exp_rd = ref_full[slot];
            chk(rsp_rdata == exp_rd, match ? "R5 forwarded data" : "R1 load data", rsp_rdata, exp_rd);
        end
        if (iss && thit) ref_full[slot] = bmerge(wd, ref_full[slot], be);
        @(posedge clk);
        #0;
        if (exp_drain) bmem[pwa[4:0]] = bmerge(pd, bmem[pwa[4:0]], pbe);
        if (iss && thit) begin
            pv = 1'b1; pwa = wa; pd = wd; pbe = be; after_rst = 1'b0;
        end else if (exp_drain) begin
            pv = 1'b0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; req_valid = 1'b0; flush = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        pv = 1'b0; after_rst = 1'b1;
        for (int s = 0; s < 32; s++) ref_full[s] = bmem[s];
    endtask

    initial begin
        #600000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [11:0] a_a, a_b, a_c;
        for (int i = 0; i < 8; i++) begin
            bvld[i] = 1'b1;
            btag[i] = 5'((i * 3) + 1);
        end
        for (int s = 0; s < 32; s++) begin
            bmem[s] = 32'hA000_0000 ^ (32'(s) * 32'h0101_0101);
            ref_full[s] = bmem[s];
        end
        pv = 1'b0; pwa = '0; pd = '0; pbe = '0; after_rst = 1'b1;
        lfsr = 32'h1D87_2B41;
        do_reset();

        // R9 / R10: reset state, idle and plain load
        step(0, 0, 12'h0, 0, 0, 0);
        a_a = mk(btag[2], 3'd2, 2'd1);
        step(1, 0, a_a, 0, 0, 0);
        // R2: first store hit, nothing pending so no write
        step(1, 1, a_a, 32'h1122_3344, 4'b0101, 0);
        // R5: partial merge on forward
        step(1, 0, a_a, 0, 0, 0);
        // R6: same slot, different tag -> miss, no forward
        @(negedge clk);
        req_valid = 1; req_store = 0; req_addr = mk(btag[2] ^ 5'd1, 3'd2, 2'd1); flush = 0;
        #1;
        chk(rsp_hit == 1'b0, "R6 tag differs", {31'b0, rsp_hit}, 32'd0);
        // R6: different word offset reads array only
        req_addr = mk(btag[2], 3'd2, 2'd2);
        #1;
        chk(rsp_rdata == bmem[5'd10], "R6 offset differs", rsp_rdata, bmem[5'd10]);
        // R4: store miss keeps entry
        step(1, 1, mk(btag[3] ^ 5'd4, 3'd3, 2'd0), 32'hDEAD_BEEF, 4'hF, 0);
        step(1, 0, a_a, 0, 0, 0);
        // R3: second store hit drains first
        a_b = mk(btag[5], 3'd5, 2'd3);
        step(1, 1, a_b, 32'hCAFE_F00D, 4'b1110, 0);
        chk(bmem[a_a[6:2]] == ref_full[a_a[6:2]], "R3 array after drain", bmem[a_a[6:2]], ref_full[a_a[6:2]]);
        // R8: flush drains, second flush is quiet
        step(0, 0, 12'h0, 0, 0, 1);
        step(0, 0, 12'h0, 0, 0, 1);
        chk(bmem[a_b[6:2]] == ref_full[a_b[6:2]], "R8 array after flush", bmem[a_b[6:2]], ref_full[a_b[6:2]]);
        // R7: parked line loses its tag, load still hits with merged data
        a_c = mk(btag[6], 3'd6, 2'd0);
        step(1, 1, a_c, 32'h5566_7788, 4'b0011, 0);
        btag[6] = btag[6] ^ 5'd8;
        step(1, 0, a_c, 0, 0, 0);
        btag[6] = btag[6] ^ 5'd8;
        // R9: reset discards pending entry
        step(1, 1, a_b, 32'h0BAD_0001, 4'hF, 0);
        do_reset();
        step(1, 0, a_b, 0, 0, 0);
        step(1, 1, a_a, 32'h7777_0000, 4'hF, 0);
        step(0, 0, 12'h0, 0, 0, 1);

        // pseudo-random sweep
        for (int n = 0; n < 3000; n++) begin
            logic [2:0] idx;
            logic [1:0] off;
            logic [4:0] tg;
            logic [3:0] kind;
            lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
            idx  = lfsr[2:0];
            off  = lfsr[4:3];
            tg   = (lfsr[6:5] == 2'b00) ? (btag[idx] ^ 5'd2) : btag[idx];
            kind = lfsr[10:7];
            if (kind < 4'd7)       step(1, 0, mk(tg, idx, off), 0, 0, lfsr[11]);
            else if (kind < 4'd13) step(1, 1, mk(tg, idx, off), lfsr ^ 32'h3C3C_5A5A, lfsr[15:12], lfsr[11]);
            else if (kind < 4'd15) step(0, 0, 12'h0, 0, 0, 1);
            else                   step(0, 0, 12'h0, 0, 0, 0);
        end
        step(0, 0, 12'h0, 0, 0, 1);
        for (int s = 0; s < 32; s++)
            chk(bmem[s] == ref_full[s], "R8 final array", bmem[s], ref_full[s]);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule